// File: doc/BRIEF.md
# One-Second Framing Error Accumulator

This block gathers receive-side performance statistics for a DS3/E3 framer channel. Two error streams arrive as single-cycle strobes from the framer: framing-parity errors and CP-bit errors. A running counter for each stream accumulates through the current one-second period. When the one-second tick arrives, both running values are copied into holding registers and the counters start again from zero.

The framing mode picks which parity strobe feeds the parity counter. Both DS3 modes use the P-bit strobe, E3 G.751 uses the BIP-4 strobe and E3 G.832 uses the BIP-8 strobe. The CP-bit counter runs only in DS3 C-bit parity mode. Software reads the snapshots one byte at a time through a small read port. A read always returns a value from the last completed period, so the two halves of a 16-bit count always come from the same snapshot. Error detection, the framer itself and the timebase are outside this block.

Top module: `pm_err_accum`

## Requirements
- R1: After reset, both holding registers are zero and every register read returns 0x00.
- R2: The mode_i encoding is 0 = DS3 M13, 1 = DS3 C-bit parity, 2 = E3 G.751 and 3 = E3 G.832. The parity counter counts p_bit_err_i in modes 0 and 1, bip4_err_i in mode 2 and bip8_err_i in mode 3. It ignores the other two parity strobes.
- R3: The CP-bit counter counts cp_err_i only in mode 1. In any other mode its running value stays zero, so the next snapshot reads zero.
- R4: On a cycle with sec_tick_i high, each holding register takes the running count of the period that is ending.
- R5: An error strobe in the same cycle as sec_tick_i is counted toward the new period.
- R6: The running counters saturate at 0xFFFF and do not wrap.
- R7: The holding registers change only on a tick. Reads repeated within a period return the same value, even while errors keep arriving.
- R8: When mode_i changes, both running counters restart from zero. A strobe in the cycle of the change is counted toward the new mode's total.
- R9: Register map: 0x70 holds the parity count high byte, 0x71 the parity low byte, 0x72 the CP-bit high byte and 0x73 the CP-bit low byte. Any other address reads 0x00. rd_data_o is updated on the clock edge that samples rd_en_i high, and it keeps its value while rd_en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Framing mode (encoding in R2) |
| p_bit_err_i | input | 1 | DS3 P-bit error strobe |
| bip4_err_i | input | 1 | E3 G.751 BIP-4 error strobe |
| bip8_err_i | input | 1 | E3 G.832 BIP-8 error strobe |
| cp_err_i | input | 1 | CP-bit error strobe |
| sec_tick_i | input | 1 | One-second period boundary strobe |
| rd_en_i | input | 1 | Register read enable |
| rd_addr_i | input | 8 | Register read address |
| rd_data_o | output | 8 | Registered read data |

## Verification
The hardest case to reach is saturation. It needs more than 65535 strobes inside a single period with no tick and no mode change, so the bench holds the P-bit strobe high for about 65.5k consecutive cycles before it issues the tick. Coincidences are the next hardest: a strobe landing on the tick cycle, and a strobe landing on the cycle where the mode changes. Directed steps place these exactly, and random strobes on all four error lines in every mode cover the common case. A reference model in the bench tracks the running and held counts, and every byte read is compared against it.

// File: rtl/pm_err_pkg.sv
package pm_err_pkg;
  typedef enum logic [1:0] {
    FRM_DS3_M13  = 2'd0,
    FRM_DS3_CBIT = 2'd1,
    FRM_E3_G751  = 2'd2,
    FRM_E3_G832  = 2'd3
  } frm_mode_e;

  localparam int unsigned NUM_ACC = 2;
  localparam int unsigned ACC_PAR = 0;
  localparam int unsigned ACC_CP  = 1;
endpackage

// File: rtl/pm_err_sel.sv
module pm_err_sel
  import pm_err_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       p_bit_err_i,
  input  logic       bip4_err_i,
  input  logic       bip8_err_i,
  input  logic       cp_err_i,
  output logic       par_inc_o,
  output logic       cp_inc_o
);
  always_comb begin
    par_inc_o = 1'b0;
    cp_inc_o  = 1'b0;
    unique case (frm_mode_e'(mode_i))
      FRM_DS3_M13:  par_inc_o = p_bit_err_i;
      FRM_DS3_CBIT: begin
        par_inc_o = p_bit_err_i;
        cp_inc_o  = cp_err_i;
      end
      FRM_E3_G751:  par_inc_o = bip4_err_i;
      FRM_E3_G832:  par_inc_o = bip8_err_i;
      default:      par_inc_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pm_sat_acc.sv
module pm_sat_acc #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             snap_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] run_o,
  output logic [CNT_W-1:0] hold_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] run_q, hold_q, base, run_d;

  // restart before adding: a coincident strobe belongs to the new period
  always_comb begin
    base  = clr_i ? '0 : run_q;
    run_d = base;
    if (inc_i && (base != CNT_MAX)) run_d = base + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      hold_q <= '0;
    end else begin
      run_q <= run_d;
      if (snap_i) hold_q <= run_q;
    end
  end

  assign run_o  = run_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/pm_reg_rd.sv
module pm_reg_rd #(
  parameter int unsigned          CNT_W    = 16,
  parameter int unsigned          ADDR_W   = 8,
  parameter int unsigned          DATA_W   = 8,
  parameter logic [ADDR_W-1:0]    PAR_BASE = 8'h70,
  parameter logic [ADDR_W-1:0]    CP_BASE  = 8'h72
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [CNT_W-1:0]  par_hold_i,
  input  logic [CNT_W-1:0]  cp_hold_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned NBYTE = CNT_W / DATA_W;

  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rd_q;

  // byte 0 at the base address is the most significant
  always_comb begin
    rd_mux = '0;
    for (int unsigned i = 0; i < NBYTE; i++) begin
      if (rd_addr_i == PAR_BASE + ADDR_W'(i))
        rd_mux = par_hold_i[CNT_W-1-i*DATA_W -: DATA_W];
      if (rd_addr_i == CP_BASE + ADDR_W'(i))
        rd_mux = cp_hold_i[CNT_W-1-i*DATA_W -: DATA_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_mux;
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/pm_err_accum.sv
module pm_err_accum
  import pm_err_pkg::*;
#(
  parameter int unsigned       CNT_W    = 16,
  parameter int unsigned       ADDR_W   = 8,
  parameter int unsigned       DATA_W   = 8,
  parameter logic [ADDR_W-1:0] PAR_BASE = 8'h70,
  parameter logic [ADDR_W-1:0] CP_BASE  = 8'h72
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              p_bit_err_i,
  input  logic              bip4_err_i,
  input  logic              bip8_err_i,
  input  logic              cp_err_i,
  input  logic              sec_tick_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [1:0]  mode_q;
  logic        mode_chg;
  logic        par_inc, cp_inc;
  logic [NUM_ACC-1:0]            inc_vec;
  logic [NUM_ACC-1:0][CNT_W-1:0] run_vec, hold_vec;
  logic [CNT_W-1:0] par_run, cp_run, par_hold, cp_hold;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= FRM_DS3_M13;
    else         mode_q <= mode_i;
  end

  assign mode_chg = (mode_i != mode_q);

  pm_err_sel u_sel (
    .mode_i      (mode_i),
    .p_bit_err_i (p_bit_err_i),
    .bip4_err_i  (bip4_err_i),
    .bip8_err_i  (bip8_err_i),
    .cp_err_i    (cp_err_i),
    .par_inc_o   (par_inc),
    .cp_inc_o    (cp_inc)
  );

  assign inc_vec[ACC_PAR] = par_inc;
  assign inc_vec[ACC_CP]  = cp_inc;

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
    pm_sat_acc #(.CNT_W(CNT_W)) u_acc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (sec_tick_i | mode_chg),
      .snap_i (sec_tick_i),
      .inc_i  (inc_vec[g]),
      .run_o  (run_vec[g]),
      .hold_o (hold_vec[g])
    );
  end

  assign par_run  = run_vec[ACC_PAR];
  assign cp_run   = run_vec[ACC_CP];
  assign par_hold = hold_vec[ACC_PAR];
  assign cp_hold  = hold_vec[ACC_CP];

  pm_reg_rd #(
    .CNT_W    (CNT_W),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PAR_BASE (PAR_BASE),
    .CP_BASE  (CP_BASE)
  ) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (rd_en_i),
    .rd_addr_i  (rd_addr_i),
    .par_hold_i (par_hold),
    .cp_hold_i  (cp_hold),
    .rd_data_o  (rd_data_o)
  );
endmodule

// File: rtl/pm_err_accum_chk.sv
module pm_err_accum_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_i,
  input logic [1:0]        mode_q,
  input logic              sec_tick_i,
  input logic              par_inc,
  input logic              rd_en_i,
  input logic [CNT_W-1:0]  par_run,
  input logic [CNT_W-1:0]  cp_run,
  input logic [CNT_W-1:0]  par_hold,
  input logic [CNT_W-1:0]  cp_hold,
  input logic [DATA_W-1:0] rd_data_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assert_cp_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'd1) |=> (cp_run == '0));

  assert_snapshot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_i |=> (par_hold == $past(par_run)) && (cp_hold == $past(cp_run)));

  assert_tick_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_i |=> (par_run == CNT_W'($past(par_inc))));

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_run == CNT_MAX) && !sec_tick_i && (mode_i == mode_q) |=> (par_run == CNT_MAX));

  assert_hold_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sec_tick_i |=> $stable(par_hold) && $stable(cp_hold));

  assert_mode_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != mode_q) |=> (par_run <= CNT_W'(1)) && (cp_run <= CNT_W'(1)));

  assert_rd_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

bind pm_err_accum pm_err_accum_chk #(
  .CNT_W  (CNT_W),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .mode_q     (mode_q),
  .sec_tick_i (sec_tick_i),
  .par_inc    (par_inc),
  .rd_en_i    (rd_en_i),
  .par_run    (par_run),
  .cp_run     (cp_run),
  .par_hold   (par_hold),
  .cp_hold    (cp_hold),
  .rd_data_o  (rd_data_o)
);

// File: tb/pm_err_accum_tb.sv
module pm_err_accum_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       p_e = 0, b4_e = 0, b8_e = 0, cp_e = 0, tick = 0;
  logic       rd_en = 0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;

  always #5 clk = ~clk;

  pm_err_accum u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mode_i      (mode),
    .p_bit_err_i (p_e),
    .bip4_err_i  (b4_e),
    .bip8_err_i  (b8_e),
    .cp_err_i    (cp_e),
    .sec_tick_i  (tick),
    .rd_en_i     (rd_en),
    .rd_addr_i   (rd_addr),
    .rd_data_o   (rd_data)
  );

  typedef struct {
    logic [7:0] exp;
    logic [7:0] addr;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  int unsigned r_par = 0, r_cp = 0, h_par = 0, h_cp = 0;
  logic [1:0]  r_mode = 2'd0;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // one cycle of stimulus plus the matching reference update
  task automatic cyc(logic p, logic b4, logic b8, logic cp, logic tk, logic [1:0] m);
    int unsigned bp, bc;
    logic pinc;
    mode = m; p_e = p; b4_e = b4; b8_e = b8; cp_e = cp; tick = tk;
    if (tk) begin h_par = r_par; h_cp = r_cp; end
    bp = (tk || m != r_mode) ? 0 : r_par;
    bc = (tk || m != r_mode) ? 0 : r_cp;
    pinc = (m <= 2'd1) ? p : (m == 2'd2) ? b4 : b8;
    r_par = (pinc && bp != 32'hFFFF) ? bp + 1 : bp;
    r_cp  = (m == 2'd1 && cp && bc != 32'hFFFF) ? bc + 1 : bc;
    r_mode = m;
    @(negedge clk);
    p_e = 0; b4_e = 0; b8_e = 0; cp_e = 0; tick = 0;
  endtask

  function automatic logic [7:0] ref_rd(logic [7:0] a);
    case (a)
      8'h70: return h_par[15:8];
      8'h71: return h_par[7:0];
      8'h72: return h_cp[15:8];
      8'h73: return h_cp[7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic rd(logic [7:0] a, string tag);
    exp_t e;
    e.exp = ref_rd(a); e.addr = a; e.tag = tag;
    exp_q.push_back(e);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic rd_all(string tag);
    rd(8'h70, tag); rd(8'h71, tag); rd(8'h72, tag); rd(8'h73, tag);
  endtask

  task automatic rand_run(int n, logic [1:0] m);
    for (int i = 0; i < n; i++)
      cyc($urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0,
          $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0, 1'b0, m);
  endtask

  // monitor: compares each read one step after the sampling edge
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en) begin
        exp_t e;
        #2;
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R9: unexpected read data 0x%02h expected none", rd_data);
        end else begin
          e = exp_q.pop_front();
          chk($sformatf("%s addr 0x%02h", e.tag, e.addr), rd_data, e.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] last;
    repeat (3) @(negedge clk);
    chk("R1 rd_data at reset", rd_data, 8'h00);
    rst_n = 1;
    @(negedge clk);
    rd_all("R1 reset snapshot");
    rd(8'h10, "R1 unmapped");

    // R2 R3 R4: random strobes in each mode, tick, read snapshot
    for (int m = 0; m < 4; m++) begin
      cyc(0, 0, 0, 0, 0, 2'(m));
      rand_run(150, 2'(m));
      cyc($urandom_range(0, 1), 1, 1, 1, 1'b1, 2'(m));
      rd_all($sformatf("R2 R3 R4 mode %0d", m));
      rand_run(40, 2'(m));
      cyc(0, 0, 0, 0, 1'b1, 2'(m));
      rd_all($sformatf("R5 R4 mode %0d carry", m));
    end

    // R5: strobe on the tick cycle counts in the next period
    cyc(0, 0, 0, 0, 1'b1, 2'd1);
    cyc(1, 0, 0, 1, 1'b1, 2'd1);
    cyc(0, 0, 0, 0, 1'b1, 2'd1);
    rd_all("R5 coincident strobe");

    // R7: holds stable while errors accumulate
    rand_run(30, 2'd1);
    cyc(0, 0, 0, 0, 1'b1, 2'd1);
    rd_all("R7 first read");
    rand_run(60, 2'd1);
    rd_all("R7 repeat read");

    // R8: mode change mid-period with a coincident strobe
    cyc(0, 0, 0, 0, 1'b1, 2'd1);
    for (int i = 0; i < 10; i++) cyc(1, 0, 0, 1, 0, 2'd1);
    cyc(1, 1, 0, 1, 0, 2'd2);
    for (int i = 0; i < 5; i++) cyc(1, 1, 1, 1, 0, 2'd2);
    cyc(0, 0, 0, 0, 1'b1, 2'd2);
    rd_all("R8 mode change");
    rd_all("R3 cp zero outside cbit");

    // R6: saturation
    cyc(0, 0, 0, 0, 1'b1, 2'd0);
    for (int i = 0; i < 65540; i++) cyc(1, 0, 0, 0, 0, 2'd0);
    cyc(0, 0, 0, 0, 1'b1, 2'd0);
    rd_all("R6 saturation");

    // R9: map edges and hold of read data
    rd(8'h74, "R9 unmapped above");
    rd(8'h6F, "R9 unmapped below");
    rd(8'h71, "R9 parity low");
    last = 8'hFF;
    repeat (4) @(negedge clk);
    chk("R9 rd_data held", rd_data, last);

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9: pending reads %0d expected 0", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule